// File: doc/BRIEF.md
# Field-Synchronized Capture Address Generator

This block produces write addresses for a capture path that stores interlaced video lines and vertical-blanking (VBI) lines into graphics memory. Software programs two VBI base addresses, one for odd fields and one for even fields, plus a pitch for the video buffer and a pitch for the VBI buffer. These go through a small synchronous register bus. The block tracks field parity and line count, and presents the VBI line start address and the video line offset on its outputs.

Base writes do not take effect at once. Each write lands in a shadow copy and raises an update-pending flag. On the first data store of the next field, both shadow bases are copied into the active bases in one cycle, so a field never mixes old and new bases. Pitch writes take effect immediately. Reads of a base return the active value, not the shadow value.

Top module: `capture_addr_gen`

## Requirements
- R1: Register word addresses are 0 = odd-field VBI base, 1 = even-field VBI base, 2 = video pitch, 3 = VBI pitch, 4 = status (bit 0 = update pending, all other bits zero). Any other address reads zero. `reg_rdata` shows, one clock after an edge, the register at the address sampled on that edge.
- R2: After reset, every register reads zero, and `vbi_line_addr` and `video_line_ofs` are zero.
- R3: Bits [3:0] of a base always read zero, whatever was written. Pitch bits [1:0] and [31:16] always read zero. A pitch write takes effect on the edge it is sampled on.
- R4: A base write leaves the readable (active) base unchanged and sets status bit 0.
- R5: The first `data_strobe` after a `field_start` commits the shadow values of both bases into the active bases and clears status bit 0. A strobe in the same cycle as `field_start` does not count as that first strobe.
- R6: A `data_strobe` that is not the first one after a `field_start` commits nothing. This covers further strobes in the same field and strobes before any field start.
- R7: If a base write and a commit fall in the same cycle, the written register's active base takes its previous shadow value. The new value stays in the shadow, status bit 0 stays set, and the other base commits normally.
- R8: `field_start` latches `field_odd` and zeroes both line offsets. `vbi_line_addr` is then the active odd base when the latched parity is 1, or the active even base when it is 0, plus the VBI line offset.
- R9: Each `line_start` adds the VBI pitch to the VBI line offset and the video pitch to `video_line_ofs`, modulo 2^32.
- R10: When `field_start` and `line_start` coincide, the field start wins and both offsets become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| field_start | input | 1 | Pulse at the start of a field |
| field_odd | input | 1 | Parity of the starting field, 1 = odd |
| line_start | input | 1 | Pulse at the start of each further line |
| data_strobe | input | 1 | Pulse for each data store to memory |
| base_pending | output | 1 | Shadow bases not yet committed |
| vbi_line_addr | output | 32 | Start address of the current VBI line |
| video_line_ofs | output | 32 | Offset of the current video line from its buffer start |

## Verification
A register write is sampled on one edge. Its readback is latched by `reg_rdata` on the next edge, so each read check drives the address on a falling edge and compares on the next falling edge. Commits, field starts and line starts act on the edge that samples them. The address outputs are combinational from those registers, so the bench checks them at the falling edge right after the event pulse. Collisions are driven in a single cycle: write with strobe, and field start with line start or strobe. Checks read the resulting state at the next falling edge.

// File: rtl/cag_pkg.sv
package cag_pkg;
  // Register word indices; bases first so a loop index maps onto them
  localparam int unsigned REG_BASE0  = 0;  // odd-field VBI base
  localparam int unsigned REG_PITCH0 = 2;  // video pitch, VBI pitch follows
  localparam int unsigned REG_STAT   = 4;
  localparam int unsigned NUM_BASE   = 2;
  localparam int unsigned NUM_PITCH  = 2;
  localparam int unsigned BASE_ODD   = 0;
  localparam int unsigned BASE_EVEN  = 1;
  localparam int unsigned PITCH_VID  = 0;
  localparam int unsigned PITCH_VBI  = 1;
endpackage

// File: rtl/cag_regfile.sv
module cag_regfile
  import cag_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PITCH_W   = 16,
  parameter int BASE_LSB  = 4,
  parameter int PITCH_LSB = 2,
  parameter int ADDR_W    = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 we,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [DATA_W-1:0]                    wdata,
  input  logic                                 commit,
  input  logic                                 pending,
  output logic                                 base_wr,
  output logic [NUM_BASE-1:0][DATA_W-1:0]      act_base,
  output logic [NUM_PITCH-1:0][PITCH_W-1:0]    pitch,
  output logic [DATA_W-1:0]                    rdata
);
  localparam logic [DATA_W-1:0]  BASE_MASK  = ~(DATA_W'((1 << BASE_LSB) - 1));
  localparam logic [PITCH_W-1:0] PITCH_MASK = ~(PITCH_W'((1 << PITCH_LSB) - 1));

  logic [NUM_BASE-1:0] base_hit;

  // Shadow and active copy per base
  for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
    logic [DATA_W-1:0] shadow_q, shadow_d;
    logic [DATA_W-1:0] active_q, active_d;

    assign base_hit[g] = we && (addr == ADDR_W'(REG_BASE0 + g));

    always_comb begin
      shadow_d = wdata & BASE_MASK;
      active_d = shadow_q;  // commit copies the value held before this edge
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        if (base_hit[g]) shadow_q <= shadow_d;
        if (commit)      active_q <= active_d;
      end
    end

    assign act_base[g] = active_q;
  end

  // Pitches are single-buffered
  for (genvar p = 0; p < NUM_PITCH; p++) begin : g_pitch
    logic               hit;
    logic [PITCH_W-1:0] pitch_q, pitch_d;

    assign hit = we && (addr == ADDR_W'(REG_PITCH0 + p));

    always_comb pitch_d = wdata[PITCH_W-1:0] & PITCH_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pitch_q <= '0;
      else if (hit) pitch_q <= pitch_d;
    end

    assign pitch[p] = pitch_q;
  end

  assign base_wr = |base_hit;

  // Registered read mux
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (addr == ADDR_W'(REG_BASE0 + BASE_ODD))        rd_d = act_base[BASE_ODD];
    else if (addr == ADDR_W'(REG_BASE0 + BASE_EVEN))  rd_d = act_base[BASE_EVEN];
    else if (addr == ADDR_W'(REG_PITCH0 + PITCH_VID)) rd_d = DATA_W'(pitch[PITCH_VID]);
    else if (addr == ADDR_W'(REG_PITCH0 + PITCH_VBI)) rd_d = DATA_W'(pitch[PITCH_VBI]);
    else if (addr == ADDR_W'(REG_STAT))               rd_d = DATA_W'(pending);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_d;
  end
endmodule

// File: rtl/cag_commit_ctl.sv
module cag_commit_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic field_start,
  input  logic data_strobe,
  input  logic base_wr,
  output logic commit,
  output logic pending
);
  logic armed_q, armed_d;
  logic pend_d;

  // First store of a field: armed by field start, disarmed by the first strobe
  always_comb begin
    commit  = data_strobe && armed_q && !field_start;
    armed_d = armed_q;
    if (field_start)      armed_d = 1'b1;
    else if (data_strobe) armed_d = 1'b0;
  end

  // A write in the commit cycle keeps the flag set
  always_comb begin
    pend_d = pending;
    if (base_wr)     pend_d = 1'b1;
    else if (commit) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pending <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pending <= pend_d;
    end
  end
endmodule

// File: rtl/cag_line_seq.sv
module cag_line_seq
  import cag_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PITCH_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              field_start,
  input  logic                              field_odd,
  input  logic                              line_start,
  input  logic [NUM_BASE-1:0][DATA_W-1:0]   act_base,
  input  logic [NUM_PITCH-1:0][PITCH_W-1:0] pitch,
  output logic [DATA_W-1:0]                 vbi_addr,
  output logic [DATA_W-1:0]                 vid_ofs
);
  logic              odd_q, odd_d;
  logic [DATA_W-1:0] vbi_ofs_q, vbi_ofs_d;
  logic [DATA_W-1:0] vid_ofs_q, vid_ofs_d;
  logic              step_en;

  always_comb begin
    step_en   = field_start || line_start;
    odd_d     = field_start ? field_odd : odd_q;
    vbi_ofs_d = vbi_ofs_q + DATA_W'(pitch[PITCH_VBI]);
    vid_ofs_d = vid_ofs_q + DATA_W'(pitch[PITCH_VID]);
    if (field_start) begin
      vbi_ofs_d = '0;
      vid_ofs_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_q     <= 1'b0;
      vbi_ofs_q <= '0;
      vid_ofs_q <= '0;
    end else if (step_en) begin
      odd_q     <= odd_d;
      vbi_ofs_q <= vbi_ofs_d;
      vid_ofs_q <= vid_ofs_d;
    end
  end

  assign vbi_addr = (odd_q ? act_base[BASE_ODD] : act_base[BASE_EVEN]) + vbi_ofs_q;
  assign vid_ofs  = vid_ofs_q;
endmodule

// File: rtl/capture_addr_gen.sv
module capture_addr_gen
  import cag_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PITCH_W   = 16,
  parameter int BASE_LSB  = 4,
  parameter int PITCH_LSB = 2,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              field_start,
  input  logic              field_odd,
  input  logic              line_start,
  input  logic              data_strobe,
  output logic              base_pending,
  output logic [DATA_W-1:0] vbi_line_addr,
  output logic [DATA_W-1:0] video_line_ofs
);
  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic                              base_wr_w;
  logic                              commit_w;
  logic [NUM_BASE-1:0][DATA_W-1:0]   act_base_w;
  logic [NUM_PITCH-1:0][PITCH_W-1:0] pitch_w;

  cag_regfile #(
    .DATA_W(DATA_W), .PITCH_W(PITCH_W), .BASE_LSB(BASE_LSB),
    .PITCH_LSB(PITCH_LSB), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .commit(commit_w), .pending(base_pending),
    .base_wr(base_wr_w), .act_base(act_base_w), .pitch(pitch_w),
    .rdata(reg_rdata)
  );

  cag_commit_ctl u_commit (
    .clk(clk), .rst_n(rst_sync_n), .field_start(field_start),
    .data_strobe(data_strobe), .base_wr(base_wr_w),
    .commit(commit_w), .pending(base_pending)
  );

  cag_line_seq #(.DATA_W(DATA_W), .PITCH_W(PITCH_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .field_start(field_start),
    .field_odd(field_odd), .line_start(line_start),
    .act_base(act_base_w), .pitch(pitch_w),
    .vbi_addr(vbi_line_addr), .vid_ofs(video_line_ofs)
  );
endmodule

// File: rtl/cag_checker.sv
module cag_checker #(
  parameter int DATA_W  = 32,
  parameter int PITCH_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               base_wr,
  input logic               commit,
  input logic               base_pending,
  input logic               field_start,
  input logic               line_start,
  input logic [DATA_W-1:0]  act_odd,
  input logic [DATA_W-1:0]  act_even,
  input logic [PITCH_W-1:0] vid_pitch,
  input logic [DATA_W-1:0]  vid_ofs
);
  p_write_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> base_pending);

  p_commit_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !base_wr) |=> !base_pending);

  p_collision_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && base_wr) |=> base_pending);

  p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_odd) && $stable(act_even)));

  p_field_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (vid_ofs == '0));

  p_line_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !field_start) |=>
      (vid_ofs == $past(vid_ofs) + DATA_W'($past(vid_pitch))));
endmodule

bind capture_addr_gen cag_checker #(.DATA_W(DATA_W), .PITCH_W(PITCH_W)) u_cag_chk (
  .clk(clk), .rst_n(rst_sync_n), .base_wr(base_wr_w), .commit(commit_w),
  .base_pending(base_pending), .field_start(field_start),
  .line_start(line_start), .act_odd(act_base_w[0]), .act_even(act_base_w[1]),
  .vid_pitch(pitch_w[0]), .vid_ofs(video_line_ofs)
);

// File: tb/capture_addr_gen_bench.sv
`timescale 1ns/1ps
module capture_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we, field_start, field_odd, line_start, data_strobe;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata, vbi_line_addr, video_line_ofs;
  logic        base_pending;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  capture_addr_gen u_capture_addr_gen (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .field_start(field_start),
    .field_odd(field_odd), .line_start(line_start), .data_strobe(data_strobe),
    .base_pending(base_pending), .vbi_line_addr(vbi_line_addr),
    .video_line_ofs(video_line_ofs)
  );

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_FS = 3'd2, OP_LS = 3'd3,
                         OP_DS = 3'd4, OP_CA = 3'd5, OP_CV = 3'd6;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 45;
  localparam vec_t VECS [NVEC] = '{
    '{OP_RD, 3'd0, 32'h0, 32'h0, 4'd2},                // R2 reset values
    '{OP_RD, 3'd1, 32'h0, 32'h0, 4'd2},
    '{OP_RD, 3'd2, 32'h0, 32'h0, 4'd2},
    '{OP_RD, 3'd3, 32'h0, 32'h0, 4'd2},
    '{OP_RD, 3'd4, 32'h0, 32'h0, 4'd2},
    '{OP_RD, 3'd5, 32'h0, 32'h0, 4'd1},                // R1 unmapped
    '{OP_CA, 3'd0, 32'h0, 32'h0, 4'd2},
    '{OP_CV, 3'd0, 32'h0, 32'h0, 4'd2},
    '{OP_WR, 3'd2, 32'hFFFF_FFFF, 32'h0, 4'd3},
    '{OP_RD, 3'd2, 32'h0, 32'h0000_FFFC, 4'd3},        // R3 pitch masking
    '{OP_WR, 3'd2, 32'h0000_0100, 32'h0, 4'd3},
    '{OP_WR, 3'd3, 32'h0000_0043, 32'h0, 4'd3},
    '{OP_RD, 3'd3, 32'h0, 32'h0000_0040, 4'd3},
    '{OP_RD, 3'd2, 32'h0, 32'h0000_0100, 4'd1},
    '{OP_WR, 3'd0, 32'h1234_567F, 32'h0, 4'd4},
    '{OP_RD, 3'd0, 32'h0, 32'h0, 4'd4},                // R4 active unchanged
    '{OP_RD, 3'd4, 32'h0, 32'h1, 4'd4},                // R4 flag set
    '{OP_WR, 3'd1, 32'h2000_0008, 32'h0, 4'd4},
    '{OP_RD, 3'd1, 32'h0, 32'h0, 4'd4},
    '{OP_DS, 3'd0, 32'h0, 32'h0, 4'd6},                // strobe before any field
    '{OP_RD, 3'd4, 32'h0, 32'h1, 4'd6},                // R6
    '{OP_FS, 3'd0, 32'h1, 32'h0, 4'd5},
    '{OP_RD, 3'd0, 32'h0, 32'h0, 4'd5},
    '{OP_CA, 3'd0, 32'h0, 32'h0, 4'd8},
    '{OP_DS, 3'd0, 32'h0, 32'h0, 4'd5},                // R5 commit
    '{OP_RD, 3'd0, 32'h0, 32'h1234_5670, 4'd5},
    '{OP_RD, 3'd1, 32'h0, 32'h2000_0000, 4'd5},
    '{OP_RD, 3'd4, 32'h0, 32'h0, 4'd5},
    '{OP_CA, 3'd0, 32'h0, 32'h1234_5670, 4'd8},        // R8 odd base
    '{OP_LS, 3'd0, 32'h0, 32'h0, 4'd9},
    '{OP_CA, 3'd0, 32'h0, 32'h1234_56B0, 4'd9},        // R9
    '{OP_CV, 3'd0, 32'h0, 32'h0000_0100, 4'd9},
    '{OP_LS, 3'd0, 32'h0, 32'h0, 4'd9},
    '{OP_CA, 3'd0, 32'h0, 32'h1234_56F0, 4'd9},
    '{OP_CV, 3'd0, 32'h0, 32'h0000_0200, 4'd9},
    '{OP_WR, 3'd0, 32'h4000_0000, 32'h0, 4'd6},
    '{OP_DS, 3'd0, 32'h0, 32'h0, 4'd6},                // second strobe of field
    '{OP_RD, 3'd0, 32'h0, 32'h1234_5670, 4'd6},
    '{OP_RD, 3'd4, 32'h0, 32'h1, 4'd6},
    '{OP_FS, 3'd0, 32'h0, 32'h0, 4'd8},
    '{OP_CA, 3'd0, 32'h0, 32'h2000_0000, 4'd8},        // R8 even base
    '{OP_CV, 3'd0, 32'h0, 32'h0, 4'd8},
    '{OP_DS, 3'd0, 32'h0, 32'h0, 4'd5},
    '{OP_RD, 3'd0, 32'h0, 32'h4000_0000, 4'd5},
    '{OP_RD, 3'd4, 32'h0, 32'h0, 4'd5}
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic fs, input logic fo, input logic ls,
                       input logic ds, input logic we,
                       input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    field_start = fs; field_odd = fo; line_start = ls; data_strobe = ds;
    reg_we = we; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    field_start = 1'b0; line_start = 1'b0; data_strobe = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd_check(input int req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    check(req, $sformatf("read addr %0d", a), reg_rdata, exp);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #500_000;  // watchdog
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    field_start = 1'b0; field_odd = 1'b0; line_start = 1'b0; data_strobe = 1'b0;
    apply_reset();

    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].op)
        OP_WR: drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, VECS[i].addr, VECS[i].data);
        OP_FS: drive(1'b1, VECS[i].data[0], 1'b0, 1'b0, 1'b0, 3'd0, 32'h0);
        OP_LS: drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0);
        OP_DS: drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
        OP_RD: rd_check(int'(VECS[i].req), VECS[i].addr, VECS[i].exp);
        OP_CA: check(int'(VECS[i].req), "vbi_line_addr", vbi_line_addr, VECS[i].exp);
        OP_CV: check(int'(VECS[i].req), "video_line_ofs", video_line_ofs, VECS[i].exp);
        default: ;
      endcase
    end

    // R7: base write in the commit cycle
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 32'h7770_0000);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 32'h0000_5550);
    rd_check(7, 3'd0, 32'h7770_0000);   // R7 other base committed
    rd_check(7, 3'd1, 32'h2000_0000);   // R7 written base kept old shadow
    rd_check(7, 3'd4, 32'h1);           // R7 flag still set
    check(7, "vbi_line_addr after collision", vbi_line_addr, 32'h7770_0000);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
    rd_check(7, 3'd1, 32'h0000_5550);   // R7 value not lost
    rd_check(7, 3'd4, 32'h0);
    check(8, "vbi_line_addr even", vbi_line_addr, 32'h0000_5550);

    // R10: field start and line start together
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0);
    check(9, "video_line_ofs two lines", video_line_ofs, 32'h0000_0200);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0);
    check(10, "video_line_ofs field+line", video_line_ofs, 32'h0);
    check(10, "vbi_line_addr field+line", vbi_line_addr, 32'h7770_0000);

    // R5: strobe in the field-start cycle does not commit
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 32'h0000_1000);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
    rd_check(5, 3'd4, 32'h1);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0);
    rd_check(5, 3'd4, 32'h0);
    rd_check(5, 3'd0, 32'h0000_1000);

    // R2: reset in mid-run
    apply_reset();
    rd_check(2, 3'd0, 32'h0);
    rd_check(2, 3'd3, 32'h0);
    rd_check(2, 3'd4, 32'h0);
    check(2, "vbi_line_addr after reset", vbi_line_addr, 32'h0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule